// File: doc/BRIEF.md
# Double-Rate Output Register Pair

This block sits in front of an output pad. It merges two single-rate data streams into one signal that changes on both halves of a clock period. Each bit lane holds two storage elements. One is clocked on the rising edge of `clk_a`. The other is clocked on the rising edge of `clk_b`, which runs 180 degrees away from `clk_a` with a 50/50 duty cycle. A phase multiplexer passes the `clk_a` element to the pad while `clk_a` is high, and the `clk_b` element while `clk_b` is high.

A second pair with the same structure registers the three-state control, so the pad can change direction at double rate as well. It has its own clock enable. The registered three-state value is active high: a 1 floats the pad and shows as `pad_oe` low. Both pairs share a set/reset and an opposite-value force.

The same structure can forward a clock. With `dat_a` tied to 1 and `dat_b` tied to 0, the pad reproduces `clk_a` through exactly the same path, and so with the same delay, as ordinary data. An enable input that has no source should be tied high, which is its active level.

Top module: `ddr_out_pad`

## Requirements
- R1: With its enable high, the `clk_a` element of a lane captures `dat_a` on the rising edge of `clk_a`, and the `clk_b` element captures `dat_b` on the rising edge of `clk_b`. The data pair uses `dat_ce` and the three-state pair uses `tri_ce`.
- R2: `pad_dat` shows the `clk_a` element while `clk_a` is high and the `clk_b` element while `clk_a` is low. Across consecutive half periods the pad therefore carries dat_a, dat_b, dat_a, dat_b.
- R3: While a pair's enable is low, both of its elements keep their value. `dat_ce` controls only the data pair and `tri_ce` controls only the three-state pair.
- R4: A high `sr` loads each element with its pair's set/reset level at that element's next rising edge. The default level is 0 for data and 1 for three-state, so after reset `pad_dat` is 0 and `pad_oe` is 0.
- R5: A high `rev` with `sr` low loads the inverse of the set/reset level. When `sr` and `rev` are both high, `sr` wins.
- R6: `pad_oe` is the inverse of the three-state element selected by the same phase rule as data. A registered 1 means the pad floats.
- R7: With `dat_a` all ones, `dat_b` all zeros and `dat_ce` high, `pad_dat` equals `clk_a` on every lane from the second clock period on.
- R8: Lanes are independent. Each lane's pad bits depend only on that lane's inputs.
- R9: `sr` and `rev` take effect whatever the level of the clock enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Clock for the first element of each pair |
| clk_b | input | 1 | Clock for the second element, 180 degrees from clk_a |
| sr | input | 1 | Load the set/reset level (dominant) |
| rev | input | 1 | Load the inverse of the set/reset level |
| dat_ce | input | 1 | Clock enable of the data pair, active high |
| tri_ce | input | 1 | Clock enable of the three-state pair, active high |
| dat_a | input | WIDTH | Data driven while clk_a is high |
| dat_b | input | WIDTH | Data driven while clk_b is high |
| tri_a | input | WIDTH | Three-state value for the clk_a phase, 1 = float |
| tri_b | input | WIDTH | Three-state value for the clk_b phase, 1 = float |
| pad_dat | output | WIDTH | Double-rate pad data |
| pad_oe | output | WIDTH | Double-rate pad drive enable, 1 = drive |

## Verification
The assertions assume three things about the inputs. `clk_b` is the exact complement of `clk_a`. `sr` and `rev` are synchronous and change only between rising edges. Every other input is stable around the edge of the element that samples it. The stimulus meets these assumptions by deriving `clk_b` by inversion and by changing every input once per period, in the middle of the high phase of `clk_a`. That point is a quarter period away from both sampling edges. The phase checks are also disabled while `sr` or `rev` is high, so that a forced load does not count as a selection error.

// File: rtl/ddr_oreg_pkg.sv
package ddr_oreg_pkg;

  typedef enum logic {
    SR_SYNC  = 1'b0,
    SR_ASYNC = 1'b1
  } sr_kind_e;

  // Next state of one storage element: force first, opposite force second,
  // then a normal load gated by the enable.
  function automatic logic elem_next(input logic sr, input logic rev,
                                     input logic ce, input logic d,
                                     input logic q, input logic sr_lvl);
    logic n;
    n = q;
    if (ce)  n = d;
    if (rev) n = ~sr_lvl;
    if (sr)  n = sr_lvl;
    return n;
  endfunction

  // Phase selection: the first element owns the high phase of its clock.
  function automatic logic phase_pick(input logic phase_hi,
                                      input logic q_first,
                                      input logic q_second);
    return phase_hi ? q_first : q_second;
  endfunction

endpackage

// File: rtl/ddr_edge_reg.sv
module ddr_edge_reg
  import ddr_oreg_pkg::*;
#(
  parameter sr_kind_e SR_KIND = SR_SYNC,
  parameter bit       SR_HIGH = 1'b0
) (
  input  logic clk,
  input  logic sr,
  input  logic rev,
  input  logic ce,
  input  logic d,
  output logic q
);

  localparam logic SR_LVL = SR_HIGH ? 1'b1 : 1'b0;

  generate
    if (SR_KIND == SR_SYNC) begin : g_sync
      always_ff @(posedge clk) begin
        q <= elem_next(sr, rev, ce, d, q, SR_LVL);
      end

      AST_CAPTURE: assert property (@(posedge clk) disable iff (sr || rev)
        ce |=> (q == $past(d))); // R1

      AST_HOLD: assert property (@(posedge clk) disable iff (sr || rev)
        !ce |=> $stable(q)); // R3

      AST_SR_WINS: assert property (@(posedge clk)
        sr |=> (q == SR_LVL)); // R4

      AST_REV_OPPOSITE: assert property (@(posedge clk)
        (rev && !sr) |=> (q == ~SR_LVL)); // R5
    end else begin : g_async
      always_ff @(posedge clk or posedge sr or posedge rev) begin
        if (sr)       q <= SR_LVL;
        else if (rev) q <= ~SR_LVL;
        else if (ce)  q <= d;
      end
    end
  endgenerate

endmodule

// File: rtl/ddr_phase_pair.sv
module ddr_phase_pair
  import ddr_oreg_pkg::*;
#(
  parameter int       WIDTH   = 2,
  parameter sr_kind_e SR_KIND = SR_SYNC,
  parameter bit       SR_HIGH = 1'b0
) (
  input  logic             clk_a,
  input  logic             clk_b,
  input  logic             sr,
  input  logic             rev,
  input  logic             ce,
  input  logic [WIDTH-1:0] d_a,
  input  logic [WIDTH-1:0] d_b,
  output logic [WIDTH-1:0] q_mux
);

  logic [WIDTH-1:0] q_first;
  logic [WIDTH-1:0] q_second;

  generate
    for (genvar ln = 0; ln < WIDTH; ln++) begin : g_lane
      ddr_edge_reg #(.SR_KIND(SR_KIND), .SR_HIGH(SR_HIGH)) u_first (
        .clk(clk_a), .sr(sr), .rev(rev), .ce(ce), .d(d_a[ln]), .q(q_first[ln])
      );
      ddr_edge_reg #(.SR_KIND(SR_KIND), .SR_HIGH(SR_HIGH)) u_second (
        .clk(clk_b), .sr(sr), .rev(rev), .ce(ce), .d(d_b[ln]), .q(q_second[ln])
      );
      assign q_mux[ln] = phase_pick(clk_a, q_first[ln], q_second[ln]);
    end
  endgenerate

  // Just before clk_b rises, clk_a is still high: first element on the pad.
  AST_A_PHASE: assert property (@(posedge clk_b) disable iff (sr || rev)
    q_mux == q_first); // R2

  // Just before clk_a rises, clk_b owns the pad.
  AST_B_PHASE: assert property (@(posedge clk_a) disable iff (sr || rev)
    q_mux == q_second); // R2

endmodule

// File: rtl/ddr_out_pad.sv
module ddr_out_pad
  import ddr_oreg_pkg::*;
#(
  parameter int       WIDTH       = 2,
  parameter sr_kind_e SR_KIND     = SR_SYNC,
  parameter bit       DAT_SR_HIGH = 1'b0,
  parameter bit       TRI_SR_HIGH = 1'b1
) (
  input  logic             clk_a,
  input  logic             clk_b,
  input  logic             sr,
  input  logic             rev,
  input  logic             dat_ce,
  input  logic             tri_ce,
  input  logic [WIDTH-1:0] dat_a,
  input  logic [WIDTH-1:0] dat_b,
  input  logic [WIDTH-1:0] tri_a,
  input  logic [WIDTH-1:0] tri_b,
  output logic [WIDTH-1:0] pad_dat,
  output logic [WIDTH-1:0] pad_oe
);

  logic [WIDTH-1:0] tri_sel;

  ddr_phase_pair #(.WIDTH(WIDTH), .SR_KIND(SR_KIND), .SR_HIGH(DAT_SR_HIGH)) u_dat_pair (
    .clk_a(clk_a), .clk_b(clk_b), .sr(sr), .rev(rev), .ce(dat_ce),
    .d_a(dat_a), .d_b(dat_b), .q_mux(pad_dat)
  );

  ddr_phase_pair #(.WIDTH(WIDTH), .SR_KIND(SR_KIND), .SR_HIGH(TRI_SR_HIGH)) u_tri_pair (
    .clk_a(clk_a), .clk_b(clk_b), .sr(sr), .rev(rev), .ce(tri_ce),
    .d_a(tri_a), .d_b(tri_b), .q_mux(tri_sel)
  );

  // A registered 1 on the three-state path releases the pad.
  assign pad_oe = ~tri_sel;

endmodule

// File: tb/ddr_out_pad_tb_top.sv
module ddr_out_pad_tb_top;
  localparam int W = 2;

  logic clk_a = 1'b0;
  logic clk_b;
  logic sr = 1'b1, rev = 1'b0, dat_ce = 1'b1, tri_ce = 1'b1;
  logic [W-1:0] dat_a = '0, dat_b = '0, tri_a = '0, tri_b = '0;
  logic [W-1:0] pad_dat, pad_oe;

  int vecs = 0;
  int errs = 0;

  // Bench model of the four element groups
  logic [W-1:0] m_da, m_db, m_ta, m_tb;

  always #10 clk_a = ~clk_a;
  assign clk_b = ~clk_a;

  ddr_out_pad #(.WIDTH(W)) dut_i (
    .clk_a(clk_a), .clk_b(clk_b), .sr(sr), .rev(rev),
    .dat_ce(dat_ce), .tri_ce(tri_ce),
    .dat_a(dat_a), .dat_b(dat_b), .tri_a(tri_a), .tri_b(tri_b),
    .pad_dat(pad_dat), .pad_oe(pad_oe)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%b exp=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  // Set-level 0 for data, 1 for three-state (R4 defaults).
  function automatic logic [W-1:0] upd(input logic [W-1:0] q, input logic [W-1:0] d,
                                       input logic en, input logic lvl);
    if (sr)  return {W{lvl}};
    if (rev) return {W{~lvl}};
    return en ? d : q;
  endfunction

  // Starts and ends a quarter period after a clk_a rising edge.
  task automatic step(input string tag, input logic [W-1:0] da, input logic [W-1:0] db,
                      input logic [W-1:0] ta, input logic [W-1:0] tb,
                      input logic dce, input logic tce, input logic s, input logic r);
    dat_a = da; dat_b = db; tri_a = ta; tri_b = tb;
    dat_ce = dce; tri_ce = tce; sr = s; rev = r;
    @(negedge clk_a);
    m_db = upd(m_db, db, dce, 1'b0);
    m_tb = upd(m_tb, tb, tce, 1'b1);
    #5;
    chk({tag, " data b-phase"}, pad_dat, m_db);
    chk({tag, " oe b-phase"}, pad_oe, ~m_tb);
    @(posedge clk_a);
    m_da = upd(m_da, da, dce, 1'b0);
    m_ta = upd(m_ta, ta, tce, 1'b1);
    #5;
    chk({tag, " data a-phase"}, pad_dat, m_da);
    chk({tag, " oe a-phase"}, pad_oe, ~m_ta);
  endtask

  initial begin
    #(200000 * 20);
    errs++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    m_da = 'x; m_db = 'x; m_ta = 'x; m_tb = 'x;
    @(posedge clk_a); #5;
    // R4: reset state
    step("R4 reset", 2'b11, 2'b11, 2'b00, 2'b00, 1'b1, 1'b1, 1'b1, 1'b0);
    chk("R4 reset pad_dat", pad_dat, 2'b00);
    chk("R4 reset pad_oe", pad_oe, 2'b00);

    // R1 R2 R6 R8: full sweep of both pairs over both lanes
    for (int v = 0; v < 256; v++) begin
      step("R1 R2 R6 R8 sweep", v[1:0], v[3:2], v[5:4], v[7:6], 1'b1, 1'b1, 1'b0, 1'b0);
    end

    // R3: data enable low holds data, three-state still loads
    step("R3 preload", 2'b10, 2'b01, 2'b00, 2'b11, 1'b1, 1'b1, 1'b0, 1'b0);
    for (int v = 0; v < 16; v++) begin
      step("R3 dat_ce low", v[1:0], v[3:2], v[3:2], v[1:0], 1'b0, 1'b1, 1'b0, 1'b0);
      chk("R3 data held a-phase", pad_dat, 2'b10);
    end
    // R3: three-state enable low holds three-state
    step("R3 preload tri", 2'b00, 2'b00, 2'b01, 2'b10, 1'b1, 1'b1, 1'b0, 1'b0);
    for (int v = 0; v < 16; v++) begin
      step("R3 tri_ce low", v[1:0], v[3:2], v[3:2], v[1:0], 1'b1, 1'b0, 1'b0, 1'b0);
      chk("R3 tri held a-phase", pad_oe, 2'b10);
    end

    // R5 and R9: opposite force with enables low, then both forces
    step("R5 R9 rev", 2'b00, 2'b00, 2'b11, 2'b11, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R5 rev pad_dat", pad_dat, 2'b11);
    chk("R5 rev pad_oe", pad_oe, 2'b11);
    step("R5 R9 sr wins", 2'b11, 2'b11, 2'b00, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R5 sr wins pad_dat", pad_dat, 2'b00);
    chk("R5 sr wins pad_oe", pad_oe, 2'b00);

    // R7: clock forwarding
    for (int k = 0; k < 8; k++) begin
      step("R7 forward", 2'b11, 2'b00, 2'b00, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0);
      chk("R7 pad follows clk_a (high)", pad_dat, {W{clk_a}});
      @(negedge clk_a); #5;
      chk("R7 pad follows clk_a (low)", pad_dat, {W{clk_a}});
      @(posedge clk_a); #5;
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule